// File: doc/BRIEF.md
# Array Processing Element with Operand Forwarding

This block is one tile of a two-dimensional coarse-grained compute array. Each clock cycle it receives a fully decoded configuration word. That word picks two 16-bit signed operands, names the arithmetic operation, and controls a small local register bank. The arithmetic unit can produce a full multiply and add every cycle, so a partial sum can stay in the element while coefficients and activations stream past. This is output-stationary accumulation.

Each operand picker can take any of these sources:
- the result outputs of the four neighbours;
- the forwarded-operand outputs of the four neighbours;
- the element's own result;
- one of four local registers;
- the immediate field of the configuration word.

One of the two picked operands is also registered onto a reuse output. Inputs can therefore hop from element to element while the element goes on computing with them. The operand paths are combinational and take no handshake. The configuration is consumed on every edge, and any back-pressure lives in the controller that sequences the words.

Top module: `pe_core`

## Requirements
- R1: After reset the accumulator, the reuse output and all four local registers read zero.
- R2: A 4-bit source select picks an operand as follows:
  - 0 to 3 take the north, south, east or west neighbour result.
  - 4 takes the element's own result.
  - 5 to 8 take register 0 to 3.
  - 9 takes the immediate.
  - 10 to 13 take the north, south, east or west neighbour forwarded operand.
  - 14 and 15 give zero.
- R3: The configuration word is 32 bits, laid out as follows:
  - bits 3:0 hold the source for operand A;
  - bits 7:4 hold the source for operand B;
  - bits 10:8 hold the opcode (0 NOP, 1 MUL, 2 ADD, 3 MAC, 4 MOV);
  - bit 11 is the reuse select;
  - bit 12 is the register write enable;
  - bits 14:13 hold the register index;
  - bit 15 is the accumulator clear;
  - bits 31:16 hold the immediate.
- R4: MUL loads the sign-extended 32-bit product A*B into the accumulator one edge later.
- R5: ADD loads the sign-extended sum A+B into the accumulator.
- R6: MAC adds the product A*B to the accumulator every cycle, with 32-bit two's-complement wrap-around.
- R7: With the clear bit set, MAC loads the product alone, and NOP loads zero.
- R8: MOV loads the sign-extended operand A. NOP without clear, and opcodes 5 to 7, leave the accumulator unchanged.
- R9: With the write enable set, operand A is stored in the indexed register and is selectable from the next cycle on.
- R10: The reuse output shows operand A (reuse select 0) or operand B (reuse select 1) one cycle after selection, whatever the opcode.
- R11: The result output is the low 16 bits of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 32 | Decoded configuration word for this cycle |
| nbr_res_i | input | 64 | Neighbour results, slices N,S,E,W at 16-bit offsets 0,16,32,48 |
| nbr_fwd_i | input | 64 | Neighbour forwarded operands, same slice order |
| pe_out_o | output | 16 | Element result (low accumulator bits) |
| acc_o | output | 32 | Full accumulator |
| fwd_o | output | 16 | Registered forwarded operand |

## Verification
The bench builds the element with its default widths: 16-bit operands, a 32-bit accumulator and four registers. With these widths the most negative operand squared reaches bit 30. Two such accumulations then cross into the sign bit, so the wrap-around corner is reached in three cycles. Every select code, including the two zero codes and all eight neighbour slices, is reachable with distinct neighbour values, so a swapped slice or code shows up directly.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  localparam int SEL_W   = 4;
  localparam int OP_W    = 3;
  localparam int IMM_W   = 16;
  localparam int RIDX_W  = 2;
  localparam int N_NBR   = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_N    = 4'd0,
    SRC_S    = 4'd1,
    SRC_E    = 4'd2,
    SRC_W    = 4'd3,
    SRC_SELF = 4'd4,
    SRC_R0   = 4'd5,
    SRC_R1   = 4'd6,
    SRC_R2   = 4'd7,
    SRC_R3   = 4'd8,
    SRC_IMM  = 4'd9,
    SRC_FN   = 4'd10,
    SRC_FS   = 4'd11,
    SRC_FE   = 4'd12,
    SRC_FW   = 4'd13,
    SRC_Z0   = 4'd14,
    SRC_Z1   = 4'd15
  } src_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_MUL = 3'd1,
    OP_ADD = 3'd2,
    OP_MAC = 3'd3,
    OP_MOV = 3'd4,
    OP_X5  = 3'd5,
    OP_X6  = 3'd6,
    OP_X7  = 3'd7
  } op_e;

  typedef struct packed {
    logic [IMM_W-1:0]  imm;
    logic              clr;
    logic [RIDX_W-1:0] rf_idx;
    logic              rf_we;
    logic              fwd_b;
    op_e               op;
    src_e              src_b;
    src_e              src_a;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pe_opnd_mux.sv
`timescale 1ns/1ps
module pe_opnd_mux
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  src_e                      sel,
  input  logic [N_NBR*DATA_W-1:0]   nbr_res,
  input  logic [N_NBR*DATA_W-1:0]   nbr_fwd,
  input  logic [DATA_W-1:0]         self_val,
  input  logic [NREG*DATA_W-1:0]    rf_flat,
  input  logic [DATA_W-1:0]         imm,
  output logic [DATA_W-1:0]         opnd
);
  always_comb begin
    opnd = '0;
    unique case (sel)
      SRC_N:    opnd = nbr_res[0*DATA_W +: DATA_W];
      SRC_S:    opnd = nbr_res[1*DATA_W +: DATA_W];
      SRC_E:    opnd = nbr_res[2*DATA_W +: DATA_W];
      SRC_W:    opnd = nbr_res[3*DATA_W +: DATA_W];
      SRC_SELF: opnd = self_val;
      SRC_R0:   opnd = rf_flat[0*DATA_W +: DATA_W];
      SRC_R1:   opnd = rf_flat[1*DATA_W +: DATA_W];
      SRC_R2:   opnd = rf_flat[2*DATA_W +: DATA_W];
      SRC_R3:   opnd = rf_flat[3*DATA_W +: DATA_W];
      SRC_IMM:  opnd = imm;
      SRC_FN:   opnd = nbr_fwd[0*DATA_W +: DATA_W];
      SRC_FS:   opnd = nbr_fwd[1*DATA_W +: DATA_W];
      SRC_FE:   opnd = nbr_fwd[2*DATA_W +: DATA_W];
      SRC_FW:   opnd = nbr_fwd[3*DATA_W +: DATA_W];
      SRC_Z0:   opnd = '0;
      SRC_Z1:   opnd = '0;
      default:  opnd = '0;
    endcase
  end
endmodule

// File: rtl/pe_regfile.sv
`timescale 1ns/1ps
module pe_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG*DATA_W-1:0] rf_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 r_q <= '0;
      else if (we && (idx == IDX_W'(g)))          r_q <= wdata;
    end
    assign rf_flat[g*DATA_W +: DATA_W] = r_q;
  end

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rf_flat[$past(idx)*DATA_W +: DATA_W] == $past(wdata)); // R9
endmodule

// File: rtl/pe_mac.sv
`timescale 1ns/1ps
module pe_mac
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  op_e                      op,
  input  logic                     clr,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [ACC_W-1:0]  acc_q
);
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, a_ext, b_ext, add_base, acc_d;

  always_comb begin
    prod     = a * b;
    prod_ext = ACC_W'(prod);
    a_ext    = ACC_W'(a);
    b_ext    = ACC_W'(b);
    add_base = clr ? '0 : acc_q;
    unique case (op)
      OP_MUL:  acc_d = prod_ext;
      OP_ADD:  acc_d = a_ext + b_ext;
      OP_MAC:  acc_d = add_base + prod_ext;
      OP_MOV:  acc_d = a_ext;
      OP_NOP:  acc_d = add_base;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_MAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MAC && !clr) |=> acc_q == $past(acc_q) + $past(prod_ext)); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP && clr) |=> acc_q == '0); // R7
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_NOP && !clr) || op == OP_X5 || op == OP_X6 || op == OP_X7) |=> $stable(acc_q)); // R8
  AST_MUL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MUL) |=> acc_q == $past(prod_ext)); // R4
endmodule

// File: rtl/pe_core.sv
`timescale 1ns/1ps
module pe_core
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int NREG   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               cfg_i,
  input  logic [N_NBR*DATA_W-1:0]   nbr_res_i,
  input  logic [N_NBR*DATA_W-1:0]   nbr_fwd_i,
  output logic [DATA_W-1:0]         pe_out_o,
  output logic [ACC_W-1:0]          acc_o,
  output logic [DATA_W-1:0]         fwd_o
);
  localparam int N_OPND = 2;

  cfg_t cfg;
  assign cfg = cfg_t'(cfg_i);

  logic [NREG*DATA_W-1:0]  rf_flat;
  logic [DATA_W-1:0]       opnd [N_OPND];
  src_e                    sel  [N_OPND];
  logic signed [ACC_W-1:0] acc_q;
  logic [DATA_W-1:0]       fwd_q;

  assign sel[0] = cfg.src_a;
  assign sel[1] = cfg.src_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_mux
    pe_opnd_mux #(.DATA_W(DATA_W), .NREG(NREG)) u_mux (
      .sel      (sel[g]),
      .nbr_res  (nbr_res_i),
      .nbr_fwd  (nbr_fwd_i),
      .self_val (acc_q[DATA_W-1:0]),
      .rf_flat  (rf_flat),
      .imm      (DATA_W'(cfg.imm)),
      .opnd     (opnd[g])
    );
  end

  pe_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg.rf_we),
    .idx     (cfg.rf_idx),
    .wdata   (opnd[0]),
    .rf_flat (rf_flat)
  );

  pe_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cfg.op),
    .clr   (cfg.clr),
    .a     (opnd[0]),
    .b     (opnd[1]),
    .acc_q (acc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fwd_q <= '0;
    else        fwd_q <= cfg.fwd_b ? opnd[1] : opnd[0];
  end

  assign fwd_o    = fwd_q;
  assign acc_o    = acc_q;
  assign pe_out_o = acc_q[DATA_W-1:0];

  AST_FWD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.src_a == SRC_IMM && !cfg.fwd_b) |=> fwd_o == $past(cfg.imm)); // R10
  AST_FWD_NBR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.src_b == SRC_FN && cfg.fwd_b) |=> fwd_o == $past(nbr_fwd_i[DATA_W-1:0])); // R10
  AST_MOV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.op == OP_MOV && cfg.src_a == SRC_Z0) |=> acc_o == '0); // R8
endmodule

// File: tb/pe_core_tb.sv
`timescale 1ns/1ps
module pe_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [63:0] nbr_res_i = '0;
  logic [63:0] nbr_fwd_i = '0;
  logic [15:0] pe_out_o, fwd_o;
  logic [31:0] acc_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int          m_acc;
  logic [15:0] m_rf [4];
  logic [15:0] m_fwd;
  logic [15:0] n_res [4];
  logic [15:0] n_fwd [4];

  always #2 clk = ~clk;

  pe_core u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .nbr_res_i(nbr_res_i),
    .nbr_fwd_i(nbr_fwd_i), .pe_out_o(pe_out_o), .acc_o(acc_o), .fwd_o(fwd_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int sa, input int sb, input int op,
                                     input bit fb, input bit we, input int idx,
                                     input bit clr, input logic [15:0] imm);
    return {imm, clr, 2'(idx), we, fb, 3'(op), 4'(sb), 4'(sa)};
  endfunction

  function automatic logic [15:0] pick(input int s, input logic [15:0] imm);
    if (s <= 3)       return n_res[s];
    else if (s == 4)  return m_acc[15:0];
    else if (s <= 8)  return m_rf[s-5];
    else if (s == 9)  return imm;
    else if (s <= 13) return n_fwd[s-10];
    else              return 16'h0;
  endfunction

  task automatic step(input logic [31:0] cw);
    logic [15:0] a, b;
    int sa, sb, op, nacc;
    sa = int'(cw[3:0]); sb = int'(cw[7:4]); op = int'(cw[10:8]);
    a = pick(sa, cw[31:16]);
    b = pick(sb, cw[31:16]);
    case (op)
      1: nacc = int'($signed(a)) * int'($signed(b));
      2: nacc = int'($signed(a)) + int'($signed(b));
      3: nacc = (cw[15] ? 0 : m_acc) + int'($signed(a)) * int'($signed(b));
      4: nacc = int'($signed(a));
      0: nacc = cw[15] ? 0 : m_acc;
      default: nacc = m_acc;
    endcase
    cfg_i = cw;
    for (int k = 0; k < 4; k++) begin
      nbr_res_i[k*16 +: 16] = n_res[k];
      nbr_fwd_i[k*16 +: 16] = n_fwd[k];
    end
    @(posedge clk);
    @(negedge clk);
    m_acc = nacc;
    if (cw[12]) m_rf[cw[14:13]] = a;
    m_fwd = cw[11] ? b : a;
    case (op)
      1: chk("R4 mul", int'(acc_o), m_acc);
      2: chk("R5 add", int'(acc_o), m_acc);
      3: chk(cw[15] ? "R7 mac clear" : "R6 mac", int'(acc_o), m_acc);
      0: chk(cw[15] ? "R7 nop clear" : "R8 nop hold", int'(acc_o), m_acc);
      default: chk("R8 mov/hold", int'(acc_o), m_acc);
    endcase
    chk("R10 reuse", int'(fwd_o), int'(m_fwd));
    chk("R11 result", int'(pe_out_o), int'(m_acc[15:0]));
  endtask

  task automatic rand_nbrs();
    for (int k = 0; k < 4; k++) begin
      n_res[k] = 16'($urandom);
      n_fwd[k] = 16'($urandom);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_acc = 0; m_fwd = '0;
    for (int k = 0; k < 4; k++) begin m_rf[k] = '0; n_res[k] = '0; n_fwd[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 acc", int'(acc_o), 0);
    chk("R1 fwd", int'(fwd_o), 0);
    for (int r = 0; r < 4; r++) begin
      step(mk(5 + r, 14, 4, 0, 0, 0, 0, 16'h0));
      chk("R1 reg", int'(acc_o), 0);
    end
    // R2: every select code, distinct neighbour values
    for (int k = 0; k < 4; k++) begin
      n_res[k] = 16'(16'h1100 * (k + 1));
      n_fwd[k] = 16'(16'h0A0 + k);
    end
    for (int s = 0; s < 16; s++) begin
      step(mk(s, 9, 4, 0, 0, 0, 0, 16'h8123));
      chk("R2 select", int'(acc_o), int'($signed(pick(s, 16'h8123))));
    end
    // R3: immediate field position and fwd of B
    step(mk(9, 9, 2, 1, 0, 0, 0, 16'h7001));
    chk("R3 imm field", int'(acc_o), 32'h0000_E002);
    // R4/R6: most negative squared then wrap
    step(mk(9, 9, 1, 0, 0, 0, 0, 16'h8000));
    step(mk(9, 9, 3, 0, 0, 0, 0, 16'h8000));
    step(mk(9, 9, 3, 0, 0, 0, 0, 16'h8000));
    chk("R6 wrap", int'(acc_o), 32'h4000_0000 + 32'h8000_0000);
    // R7: clear with MAC and with NOP
    step(mk(9, 0, 3, 0, 0, 0, 1, 16'h0003));
    step(mk(0, 0, 0, 0, 0, 0, 1, 16'h0));
    chk("R7 nop clear", int'(acc_o), 0);
    // R8: reserved opcodes hold
    step(mk(9, 9, 1, 0, 0, 0, 0, 16'h0101));
    for (int op = 5; op < 8; op++) step(mk(9, 9, op, 0, 0, 0, 0, 16'h7777));
    chk("R8 reserved hold", int'(acc_o), 32'h0001_0201);
    // R9: write each register, read back
    for (int r = 0; r < 4; r++) step(mk(9, 14, 0, 0, 1, r, 0, 16'(16'hC000 + r)));
    for (int r = 0; r < 4; r++) begin
      step(mk(5 + r, 14, 4, 0, 0, 0, 0, 16'h0));
      chk("R9 reg readback", int'(acc_o), int'($signed(16'(16'hC000 + r))));
    end
    // R10: forward B while NOP
    step(mk(9, 12, 0, 1, 0, 0, 0, 16'h1234));
    chk("R10 fwd B", int'(fwd_o), int'(n_fwd[2]));
    // random mix
    for (int i = 0; i < 600; i++) begin
      rand_nbrs();
      step($urandom);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule